// File: doc/BRIEF.md
# Operand-Coded Register File

This block holds the working registers of a small 16-bit processor: four general-purpose registers (R0 to R3) and four index registers (stack pointer, data pointer, interrupt address, program counter). It has one read port and one write port. Neither port takes a plain register number. Each takes an operand code of the kind an instruction carries, and the code picks both the register and the width of the access.

A general-purpose register can be used as a full 16-bit word or as either of its two bytes. The byte codes alias onto the word registers, so a byte write changes one half of a word register and leaves the other half alone. The index registers can only be used as whole words. Codes that name no register access raise a flag on the port that used them. Such a code returns zero on a read and changes nothing on a write.

Reads are combinational from the current register contents. Writes take effect at the rising clock edge.

Top module: `opreg_file`

## Requirements
- R1: Codes 0x00 to 0x07 read and write the full 16-bit registers in this order: R0, R1, R2, R3, SP, DP, IR, PC.
- R2: Codes 0x08, 0x09, 0x0A and 0x0B select the low byte (bits 7:0) of R0, R1, R2 and R3.
- R3: Codes 0x0D, 0x0E, 0x0F and 0x10 select the high byte (bits 15:8) of R0, R1, R2 and R3. The byte to store is taken from wr_data[7:0] for both low-byte and high-byte writes.
- R4: A byte write changes only the selected half of the target register. The other half keeps its value.
- R5: A byte read returns the selected byte on rd_data[7:0] and drives rd_data[15:8] to zero.
- R6: Code 0x0C and every code above 0x10 are invalid. On a read with such a code, rd_bad is 1 and rd_data is zero. For all valid codes, rd_bad is 0.
- R7: A write with wr_en high and an invalid code changes no register, and wr_bad is 1 in that cycle. When wr_en is low, wr_bad is 0.
- R8: A synchronous active-high reset clears all eight registers to zero, and it takes priority over a write in the same cycle.
- R9: A write updates its register at the rising clock edge. A read of the same register in the same cycle returns the value from before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| rd_code | input | 8 | Operand code for the read port |
| rd_data | output | 16 | Read data; byte reads are zero-extended |
| rd_bad | output | 1 | The read code is invalid |
| wr_en | input | 1 | Write request |
| wr_code | input | 8 | Operand code for the write port |
| wr_data | input | 16 | Write data; a byte write uses bits 7:0 |
| wr_bad | output | 1 | A write was requested with an invalid code |

## Verification
The hardest case to reach is a mix of byte and word writes to the same general register, read back through its other aliases. The high byte must be seen to survive a low-byte write, and the low byte to survive a high-byte write. The stimulus builds such a value in directed steps and then reads it back through all three codes of that register. It also issues writes with code 0x0C and codes just above 0x10 while reading the registers those codes would hit if decoded wrongly. A long random run with codes biased toward the valid range then mixes overlapping byte and word writes, and a behavioural model checks every cycle.

// File: rtl/oprf_pkg.sv
package oprf_pkg;

    localparam int CODE_W   = 8;
    localparam int NUM_GP   = 4;
    localparam int NUM_IX   = 4;
    localparam int NUM_REGS = NUM_GP + NUM_IX;
    localparam int IDX_W    = $clog2(NUM_REGS);

    localparam int WORD_BASE = 0;
    localparam int LO_BASE   = WORD_BASE + NUM_REGS;
    localparam int HI_BASE   = LO_BASE + NUM_GP + 1;

    typedef enum logic [1:0] {
        K_WORD = 2'd0,
        K_LO   = 2'd1,
        K_HI   = 2'd2,
        K_BAD  = 2'd3
    } kind_e;

    typedef struct packed {
        kind_e             kind;
        logic [IDX_W-1:0]  idx;
    } sel_t;

    function automatic sel_t decode_code(input logic [CODE_W-1:0] code);
        sel_t s;
        int   c;
        c = int'(code);
        s.kind = K_BAD;
        s.idx  = '0;
        if (c >= WORD_BASE && c < WORD_BASE + NUM_REGS) begin
            s.kind = K_WORD;
            s.idx  = IDX_W'(c - WORD_BASE);
        end else if (c >= LO_BASE && c < LO_BASE + NUM_GP) begin
            s.kind = K_LO;
            s.idx  = IDX_W'(c - LO_BASE);
        end else if (c >= HI_BASE && c < HI_BASE + NUM_GP) begin
            s.kind = K_HI;
            s.idx  = IDX_W'(c - HI_BASE);
        end
        return s;
    endfunction

endpackage

// File: rtl/oprf_decode.sv
module oprf_decode
    import oprf_pkg::*;
(
    input  logic [CODE_W-1:0] code,
    output sel_t              sel
);
    always_comb sel = decode_code(code);
endmodule

// File: rtl/oprf_store.sv
module oprf_store #(
    parameter int DATA_W = 16,
    parameter int NREG   = 8
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic [NREG-1:0]               we_lo,
    input  logic [NREG-1:0]               we_hi,
    input  logic [DATA_W/2-1:0]           byte_lo,
    input  logic [DATA_W/2-1:0]           byte_hi,
    output logic [NREG-1:0][DATA_W-1:0]   regs
);
    localparam int HALF = DATA_W / 2;

    for (genvar g = 0; g < NREG; g++) begin : g_reg
        always_ff @(posedge clk) begin
            if (rst)
                regs[g][HALF-1:0] <= '0;
            else if (we_lo[g])
                regs[g][HALF-1:0] <= byte_lo;
        end
        always_ff @(posedge clk) begin
            if (rst)
                regs[g][DATA_W-1:HALF] <= '0;
            else if (we_hi[g])
                regs[g][DATA_W-1:HALF] <= byte_hi;
        end
    end
endmodule

// File: rtl/oprf_rdmux.sv
module oprf_rdmux
    import oprf_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int NREG   = 8
) (
    input  logic [NREG-1:0][DATA_W-1:0] regs,
    input  sel_t                        sel,
    output logic [DATA_W-1:0]           data,
    output logic                        bad
);
    localparam int HALF = DATA_W / 2;

    logic [DATA_W-1:0] word;

    always_comb begin
        word = regs[sel.idx];
        bad  = 1'b0;
        data = '0;
        unique case (sel.kind)
            K_WORD: data = word;
            K_LO:   data = {{HALF{1'b0}}, word[HALF-1:0]};
            K_HI:   data = {{HALF{1'b0}}, word[DATA_W-1:HALF]};
            default: bad = 1'b1;
        endcase
    end
endmodule

// File: rtl/opreg_file.sv
module opreg_file
    import oprf_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [CODE_W-1:0]   rd_code,
    output logic [DATA_W-1:0]   rd_data,
    output logic                rd_bad,
    input  logic                wr_en,
    input  logic [CODE_W-1:0]   wr_code,
    input  logic [DATA_W-1:0]   wr_data,
    output logic                wr_bad
);
    localparam int HALF = DATA_W / 2;

    sel_t rd_sel;
    sel_t wr_sel;
    logic [NUM_REGS-1:0]              we_lo;
    logic [NUM_REGS-1:0]              we_hi;
    logic [HALF-1:0]                  byte_lo;
    logic [HALF-1:0]                  byte_hi;
    logic [NUM_REGS-1:0][DATA_W-1:0]  regs;

    oprf_decode u_rd_dec (.code(rd_code), .sel(rd_sel));
    oprf_decode u_wr_dec (.code(wr_code), .sel(wr_sel));

    always_comb begin
        we_lo   = '0;
        we_hi   = '0;
        byte_lo = wr_data[HALF-1:0];
        byte_hi = wr_data[DATA_W-1:HALF];
        wr_bad  = 1'b0;
        if (wr_en) begin
            unique case (wr_sel.kind)
                K_WORD: begin
                    we_lo[wr_sel.idx] = 1'b1;
                    we_hi[wr_sel.idx] = 1'b1;
                end
                K_LO: we_lo[wr_sel.idx] = 1'b1;
                K_HI: begin
                    we_hi[wr_sel.idx] = 1'b1;
                    byte_hi = wr_data[HALF-1:0];
                end
                default: wr_bad = 1'b1;
            endcase
        end
    end

    oprf_store #(.DATA_W(DATA_W), .NREG(NUM_REGS)) u_store (
        .clk(clk), .rst(rst), .we_lo(we_lo), .we_hi(we_hi),
        .byte_lo(byte_lo), .byte_hi(byte_hi), .regs(regs)
    );

    oprf_rdmux #(.DATA_W(DATA_W), .NREG(NUM_REGS)) u_rdmux (
        .regs(regs), .sel(rd_sel), .data(rd_data), .bad(rd_bad)
    );
endmodule

// File: rtl/oprf_chk.sv
module oprf_chk #(
    parameter int DATA_W = 16,
    parameter int CODE_W = 8
) (
    input logic              clk,
    input logic              rst,
    input logic [CODE_W-1:0] rd_code,
    input logic [DATA_W-1:0] rd_data,
    input logic              rd_bad,
    input logic              wr_en,
    input logic [CODE_W-1:0] wr_code,
    input logic [DATA_W-1:0] wr_data,
    input logic              wr_bad
);
    localparam int HALF = DATA_W / 2;

    logic rd_is_byte;
    assign rd_is_byte = (rd_code >= CODE_W'(8)) && (rd_code <= CODE_W'(16))
                        && (rd_code != CODE_W'(12));

    // R8
    reset_clears_chk: assert property (@(posedge clk) rst |=> rd_data == '0);

    // R6
    bad_read_zero_chk: assert property (@(posedge clk) disable iff (rst)
        rd_bad |-> rd_data == '0);

    // R5
    byte_zero_ext_chk: assert property (@(posedge clk) disable iff (rst)
        rd_is_byte |-> rd_data[DATA_W-1:HALF] == '0);

    // R7
    idle_no_bad_chk: assert property (@(posedge clk) disable iff (rst)
        !wr_en |-> !wr_bad);

    // R7
    no_write_stable_chk: assert property (@(posedge clk) disable iff (rst)
        ($past(!wr_en || wr_bad) && !$past(rst) && rd_code == $past(rd_code))
        |-> rd_data == $past(rd_data));

    // R9
    word_write_seen_chk: assert property (@(posedge clk) disable iff (rst)
        ($past(wr_en && wr_code < CODE_W'(8) && rd_code == wr_code) && !$past(rst)
         && rd_code == $past(rd_code))
        |-> rd_data == $past(wr_data));
endmodule

bind opreg_file oprf_chk #(.DATA_W(DATA_W), .CODE_W(oprf_pkg::CODE_W)) u_chk (
    .clk(clk), .rst(rst), .rd_code(rd_code), .rd_data(rd_data), .rd_bad(rd_bad),
    .wr_en(wr_en), .wr_code(wr_code), .wr_data(wr_data), .wr_bad(wr_bad)
);

// File: tb/opreg_file_tb.sv
module opreg_file_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [7:0]  rd_code = 8'h00;
    logic [15:0] rd_data;
    logic        rd_bad;
    logic        wr_en = 1'b0;
    logic [7:0]  wr_code = 8'h00;
    logic [15:0] wr_data = 16'h0000;
    logic        wr_bad;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 0;
    logic [15:0] model [8];

    always #10 clk = ~clk;

    opreg_file u_dut (
        .clk(clk), .rst(rst), .rd_code(rd_code), .rd_data(rd_data), .rd_bad(rd_bad),
        .wr_en(wr_en), .wr_code(wr_code), .wr_data(wr_data), .wr_bad(wr_bad)
    );

    // kind: 0 word, 1 low byte, 2 high byte, 3 invalid
    function automatic int kind_of(input logic [7:0] c);
        if (c <= 8'h07) return 0;
        if (c >= 8'h08 && c <= 8'h0B) return 1;
        if (c >= 8'h0D && c <= 8'h10) return 2;
        return 3;
    endfunction

    function automatic int reg_of(input logic [7:0] c);
        case (kind_of(c))
            0: return int'(c);
            1: return int'(c) - 8;
            2: return int'(c) - 13;
            default: return 0;
        endcase
    endfunction

    function automatic logic [15:0] model_read(input logic [7:0] c);
        case (kind_of(c))
            0: return model[reg_of(c)];
            1: return {8'h00, model[reg_of(c)][7:0]};
            2: return {8'h00, model[reg_of(c)][15:8]};
            default: return 16'h0000;
        endcase
    endfunction

    function automatic string tag_of(input logic [7:0] c);
        case (kind_of(c))
            0: return "R1";
            1: return "R2";
            2: return "R3";
            default: return "R6";
        endcase
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual %h expected %h (rd_code %h wr_code %h)",
                     req, act, exp, rd_code, wr_code);
        end
    endtask

    // Drive inputs at the falling edge, check outputs, then advance the model by one edge.
    task automatic step(input logic r, input logic [7:0] rc, input logic we,
                        input logic [7:0] wc, input logic [15:0] wd, input string extra);
        @(negedge clk);
        rst = r; rd_code = rc; wr_en = we; wr_code = wc; wr_data = wd;
        #2;
        if (!r) begin
            check(extra.len() > 0 ? extra : tag_of(rc), 32'(rd_data), 32'(model_read(rc)));
            check("R6", 32'(rd_bad), 32'(kind_of(rc) == 3));
            check("R7", 32'(wr_bad), 32'(we && kind_of(wc) == 3));
            if (kind_of(rc) == 1 || kind_of(rc) == 2)
                check("R5", 32'(rd_data[15:8]), 32'h0);
        end
        @(posedge clk);
        if (r) begin
            for (int i = 0; i < 8; i++) model[i] = 16'h0000;
        end else if (we) begin
            case (kind_of(wc))
                0: model[reg_of(wc)] = wd;
                1: model[reg_of(wc)][7:0] = wd[7:0];
                2: model[reg_of(wc)][15:8] = wd[7:0];
                default: ;
            endcase
        end
    endtask

    initial begin
        #4_000_000;
        if (!done) begin
            n_fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 8; i++) model[i] = 16'hDEAD;
        step(1, 8'h00, 0, 8'h00, 16'h0, "");
        step(1, 8'h00, 1, 8'h03, 16'hFFFF, "");   // reset wins over write
        // R8: every code reads zero after reset
        for (int c = 0; c < 20; c++) step(0, 8'(c), 0, 8'h00, 16'h0, "R8");

        // R1: fill all eight word registers with distinct values, read each back
        for (int i = 0; i < 8; i++) step(0, 8'h00, 1, 8'(i), 16'(16'h1111 * (i + 1) ^ 16'h0F0F), "");
        for (int i = 0; i < 8; i++) step(0, 8'(i), 0, 8'h00, 16'h0, "R1");

        // R4: byte writes keep the other half
        step(0, 8'h01, 1, 8'h01, 16'hA5C3, "R9");
        step(0, 8'h01, 1, 8'h09, 16'hFF7E, "R9");   // low byte of R1
        step(0, 8'h01, 1, 8'h0E, 16'h0011, "R4");   // high byte of R1 from bits 7:0
        step(0, 8'h01, 0, 8'h00, 16'h0, "R4");
        step(0, 8'h09, 0, 8'h00, 16'h0, "R4");
        step(0, 8'h0E, 0, 8'h00, 16'h0, "R4");

        // R7: invalid writes aimed between and beyond the valid ranges
        step(0, 8'h03, 1, 8'h0C, 16'hBEEF, "R7");
        step(0, 8'h00, 1, 8'h11, 16'hBEEF, "R7");
        step(0, 8'h07, 1, 8'hFF, 16'hBEEF, "R7");
        for (int i = 0; i < 8; i++) step(0, 8'(i), 0, 8'h00, 16'h0, "R7");

        // R6: invalid reads
        step(0, 8'h0C, 0, 8'h00, 16'h0, "R6");
        step(0, 8'h11, 0, 8'h00, 16'h0, "R6");
        step(0, 8'h80, 0, 8'h00, 16'h0, "R6");

        // R9: same-cycle read shows old value, next cycle shows new
        step(0, 8'h06, 1, 8'h06, 16'h1234, "R9");
        step(0, 8'h06, 0, 8'h00, 16'h0, "R9");
        step(0, 8'h0A, 1, 8'h0A, 16'h0056, "R9");
        step(0, 8'h0A, 0, 8'h00, 16'h0, "R9");

        // Random mix, codes biased toward 0x00..0x13
        for (int n = 0; n < 3000; n++) begin
            logic [7:0] rc, wc;
            rc = ($urandom_range(0, 15) == 0) ? 8'($urandom) : 8'($urandom_range(0, 19));
            wc = ($urandom_range(0, 15) == 0) ? 8'($urandom) : 8'($urandom_range(0, 19));
            step(0, rc, 1'($urandom), wc, 16'($urandom), "");
        end

        // R8: reset mid-run clears again
        step(1, 8'h00, 0, 8'h00, 16'h0, "");
        for (int i = 0; i < 8; i++) step(0, 8'(i), 0, 8'h00, 16'h0, "R8");

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end
endmodule